// File: doc/BRIEF.md
# 32-Pin GPIO Bank Controller

The block is a bank of general-purpose I/O pins controlled through a simple APB-style register bus. Each pin has a stored output level, a direction, a bit that switches its pull resistor off, and a two-bit selector that picks between plain GPIO and three alternate functions. Software can write the level and direction registers whole. It can also change single pins through separate set and clear aliases, so it never needs a read-modify-write sequence.

The pin's stored level has two uses. When the pin drives, it is the driven value. When the pin is an input, it selects whether the pull resistor pulls up or pulls down. The pad levels pass through a synchroniser before the bus can read them, so reads of the level register always return recent, metastability-filtered pin states. Writes complete on the access phase of the bus cycle with no wait states. Reads are served from combinational decode.

Top module: `pinbank_ctrl`

## Requirements
- R1: While `presetn` is low and after its release, every pin is an input (`pad_oe`=0) with stored level 0 (`pad_out`=0). Every pull is enabled and pulls down (`pad_pull_en` all ones, `pad_pull_up`=0). Every alternate select is 0 (`pad_alt`=0).
- R2: A write to offset 0x00 loads all 32 stored levels from `pwdata`. The result shows on `pad_out` after the write edge. Bit n always belongs to pin n.
- R3: A write to offset 0x04 sets the stored level of each pin whose `pwdata` bit is 1. Pins written with 0 keep their level.
- R4: A write to offset 0x08 clears the stored level of each pin whose `pwdata` bit is 1. Pins written with 0 keep their level.
- R5: Direction is written whole at 0x10, set per bit at 0x14 and cleared per bit at 0x18, with the same rules as R2 to R4. A direction bit of 1 drives the pin (`pad_oe`=1).
- R6: The pull-off register at 0x0C disables pin n's pull when bit n is 1. While the pull is enabled, `pad_pull_up` bit n equals the stored level (1 = up, 0 = down).
- R7: A driving pin never has its pull enabled. Setting the stored level of a driving pin changes `pad_out`.
- R8: Alternate select A at 0x20 and select B at 0x24 give each pin n the code `pad_alt[2n+1:2n]` = {B bit n, A bit n}. Code 0 means plain GPIO.
- R9: A read of 0x00 returns the pad levels after two register stages. A level sampled at a clock edge is visible after the next edge, and not before.
- R10: Reads of 0x0C, 0x10, 0x20 and 0x24 return the stored register values. Reads of the alias offsets 0x04, 0x08, 0x14 and 0x18 return 0.
- R11: Offsets outside the map (for example 0x1C and 0x40) read as 0. Writes to them change no pad output and no register.
- R12: A write takes effect only in a cycle with `psel`, `penable` and `pwrite` all high. A setup-phase cycle (`penable` low) changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and bank clock |
| presetn | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | Bank selected |
| penable | input | 1 | Access phase of a bus cycle |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte offset of the register |
| pwdata | input | 32 | Write data, bit n for pin n |
| prdata | output | 32 | Read data, zero when not selected |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_oe | output | 32 | Pad drive enable per pin |
| pad_out | output | 32 | Pad drive value per pin |
| pad_pull_en | output | 32 | Pull resistor enable per pin |
| pad_pull_up | output | 32 | Pull direction per pin, 1 = up |
| pad_alt | output | 64 | Function code per pin, two bits each |

## Verification
The hardest case to reach from the ports is the shared use of the stored level. The same bit must act as the pull direction on inputs and as the driven value on outputs, and the pull must fall away the moment a pin turns into an output. The stimulus first builds a mixed direction pattern through the set and clear aliases. It then disables a few pulls and sets the level of a pin that is already driving. After each step it compares the pull enable, pull direction and drive value of every pin together. The synchroniser latency is checked by changing `pad_in` between edges and reading the level register in consecutive cycles, so an early or late stage shows at once.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    // Word index of each register (byte offset >> 2)
    typedef enum logic [3:0] {
        RS_LVL      = 4'd0,
        RS_LVL_SET  = 4'd1,
        RS_LVL_CLR  = 4'd2,
        RS_PULLOFF  = 4'd3,
        RS_DIR      = 4'd4,
        RS_DIR_SET  = 4'd5,
        RS_DIR_CLR  = 4'd6,
        RS_FN_A     = 4'd8,
        RS_FN_B     = 4'd9,
        RS_NONE     = 4'd15
    } regsel_e;

    localparam int WORD_LSB = 2;
    localparam int IDX_W    = 4;

endpackage

// File: rtl/pinbank_decode.sv
module pinbank_decode
    import pinbank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output regsel_e           sel
);

    localparam int HI_LSB = WORD_LSB + IDX_W;

    logic in_window;

    assign in_window = (addr[ADDR_W-1:HI_LSB] == '0) && (addr[WORD_LSB-1:0] == '0);

    always_comb begin
        sel = RS_NONE;
        if (in_window) begin
            case (addr[HI_LSB-1:WORD_LSB])
                4'd0:    sel = RS_LVL;
                4'd1:    sel = RS_LVL_SET;
                4'd2:    sel = RS_LVL_CLR;
                4'd3:    sel = RS_PULLOFF;
                4'd4:    sel = RS_DIR;
                4'd5:    sel = RS_DIR_SET;
                4'd6:    sel = RS_DIR_CLR;
                4'd8:    sel = RS_FN_A;
                4'd9:    sel = RS_FN_B;
                default: sel = RS_NONE;
            endcase
        end
    end

endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
    import pinbank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  regsel_e          sel,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] lvl,
    output logic [NPINS-1:0] dir,
    output logic [NPINS-1:0] pulloff,
    output logic [NPINS-1:0] fn_a,
    output logic [NPINS-1:0] fn_b
);

    typedef struct packed {
        logic [NPINS-1:0] lvl;
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] pulloff;
        logic [NPINS-1:0] fn_a;
        logic [NPINS-1:0] fn_b;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (sel)
                RS_LVL:     st_d.lvl     = wdata;
                RS_LVL_SET: st_d.lvl     = st_q.lvl | wdata;
                RS_LVL_CLR: st_d.lvl     = st_q.lvl & ~wdata;
                RS_PULLOFF: st_d.pulloff = wdata;
                RS_DIR:     st_d.dir     = wdata;
                RS_DIR_SET: st_d.dir     = st_q.dir | wdata;
                RS_DIR_CLR: st_d.dir     = st_q.dir & ~wdata;
                RS_FN_A:    st_d.fn_a    = wdata;
                RS_FN_B:    st_d.fn_b    = wdata;
                default:    st_d         = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl     = st_q.lvl;
    assign dir     = st_q.dir;
    assign pulloff = st_q.pulloff;
    assign fn_a    = st_q.fn_a;
    assign fn_b    = st_q.fn_b;

endmodule

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int NPINS  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] din,
    output logic [NPINS-1:0] dout
);

    logic [STAGES-1:0][NPINS-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/pinbank_pad.sv
module pinbank_pad #(
    parameter int NPINS = 32
) (
    input  logic [NPINS-1:0]   lvl,
    input  logic [NPINS-1:0]   dir,
    input  logic [NPINS-1:0]   pulloff,
    input  logic [NPINS-1:0]   fn_a,
    input  logic [NPINS-1:0]   fn_b,
    output logic [NPINS-1:0]   oe,
    output logic [NPINS-1:0]   dout,
    output logic [NPINS-1:0]   pull_en,
    output logic [NPINS-1:0]   pull_up,
    output logic [2*NPINS-1:0] fn_code
);

    assign oe      = dir;
    assign dout    = lvl;
    assign pull_up = lvl;

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        // pull active only on a non-driving pin whose pull-off bit is clear
        assign pull_en[g]       = ~pulloff[g] & ~dir[g];
        assign fn_code[2*g +: 2] = {fn_b[g], fn_a[g]};
    end

endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
    import pinbank_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 8,
    parameter int STAGES = 2
) (
    input  logic                pclk,
    input  logic                presetn,
    input  logic                psel,
    input  logic                penable,
    input  logic                pwrite,
    input  logic [ADDR_W-1:0]   paddr,
    input  logic [NPINS-1:0]    pwdata,
    output logic [NPINS-1:0]    prdata,
    input  logic [NPINS-1:0]    pad_in,
    output logic [NPINS-1:0]    pad_oe,
    output logic [NPINS-1:0]    pad_out,
    output logic [NPINS-1:0]    pad_pull_en,
    output logic [NPINS-1:0]    pad_pull_up,
    output logic [2*NPINS-1:0]  pad_alt
);

    regsel_e          sel;
    logic             wr_en;
    logic [NPINS-1:0] lvl, dir, pulloff, fn_a, fn_b;
    logic [NPINS-1:0] pins_sync;

    assign wr_en = psel & penable & pwrite;

    pinbank_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (paddr),
        .sel  (sel)
    );

    pinbank_regs #(.NPINS(NPINS)) u_regs (
        .clk     (pclk),
        .rst_n   (presetn),
        .wr_en   (wr_en),
        .sel     (sel),
        .wdata   (pwdata),
        .lvl     (lvl),
        .dir     (dir),
        .pulloff (pulloff),
        .fn_a    (fn_a),
        .fn_b    (fn_b)
    );

    pinbank_sync #(.NPINS(NPINS), .STAGES(STAGES)) u_sync (
        .clk   (pclk),
        .rst_n (presetn),
        .din   (pad_in),
        .dout  (pins_sync)
    );

    pinbank_pad #(.NPINS(NPINS)) u_pad (
        .lvl     (lvl),
        .dir     (dir),
        .pulloff (pulloff),
        .fn_a    (fn_a),
        .fn_b    (fn_b),
        .oe      (pad_oe),
        .dout    (pad_out),
        .pull_en (pad_pull_en),
        .pull_up (pad_pull_up),
        .fn_code (pad_alt)
    );

    // Read path: aliases and unmapped offsets return zero
    always_comb begin
        prdata = '0;
        if (psel) begin
            case (sel)
                RS_LVL:     prdata = pins_sync;
                RS_PULLOFF: prdata = pulloff;
                RS_DIR:     prdata = dir;
                RS_FN_A:    prdata = fn_a;
                RS_FN_B:    prdata = fn_b;
                default:    prdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/pinbank_chk.sv
module pinbank_chk #(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 8
) (
    input logic                pclk,
    input logic                presetn,
    input logic                psel,
    input logic                penable,
    input logic                pwrite,
    input logic [ADDR_W-1:0]   paddr,
    input logic [NPINS-1:0]    pwdata,
    input logic [NPINS-1:0]    pad_in,
    input logic [NPINS-1:0]    pad_oe,
    input logic [NPINS-1:0]    pad_out,
    input logic [NPINS-1:0]    pad_pull_en,
    input logic [2*NPINS-1:0]  pad_alt,
    input logic [NPINS-1:0]    pins_sync
);

    logic       wr;
    logic [1:0] age_q;

    assign wr = psel && penable && pwrite;

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
            age_q <= 2'd0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge pclk)
        !presetn |=> (pad_oe == '0) && (pad_out == '0) && (pad_alt == '0));

    assert_set_alias_R3: assert property (@(posedge pclk) disable iff (!presetn)
        (wr && paddr == ADDR_W'(8'h04)) |=> ((pad_out & $past(pwdata)) == $past(pwdata)));

    assert_clr_alias_R4: assert property (@(posedge pclk) disable iff (!presetn)
        (wr && paddr == ADDR_W'(8'h08)) |=> ((pad_out & $past(pwdata)) == '0));

    assert_dir_set_R5: assert property (@(posedge pclk) disable iff (!presetn)
        (wr && paddr == ADDR_W'(8'h14)) |=> ((pad_oe & $past(pwdata)) == $past(pwdata)));

    assert_no_pull_on_drive_R7: assert property (@(posedge pclk) disable iff (!presetn)
        (pad_pull_en & pad_oe) == '0);

    assert_sync_delay_R9: assert property (@(posedge pclk) disable iff (!presetn)
        (age_q >= 2'd2) |-> (pins_sync == $past(pad_in, 2)));

    assert_unmapped_quiet_R11: assert property (@(posedge pclk) disable iff (!presetn)
        (wr && paddr == ADDR_W'(8'h1C)) |=> ($stable(pad_out) && $stable(pad_oe) && $stable(pad_alt)));

    assert_idle_quiet_R12: assert property (@(posedge pclk) disable iff (!presetn)
        !wr |=> ($stable(pad_out) && $stable(pad_oe) && $stable(pad_alt) && $stable(pad_pull_en)));

endmodule

bind pinbank_ctrl pinbank_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
    .pclk        (pclk),
    .presetn     (presetn),
    .psel        (psel),
    .penable     (penable),
    .pwrite      (pwrite),
    .paddr       (paddr),
    .pwdata      (pwdata),
    .pad_in      (pad_in),
    .pad_oe      (pad_oe),
    .pad_out     (pad_out),
    .pad_pull_en (pad_pull_en),
    .pad_alt     (pad_alt),
    .pins_sync   (pins_sync)
);

// File: tb/pinbank_ctrl_bench.sv
module pinbank_ctrl_bench;

    logic        pclk = 1'b0;
    logic        presetn;
    logic        psel, penable, pwrite;
    logic [7:0]  paddr;
    logic [31:0] pwdata, prdata, pad_in;
    logic [31:0] pad_oe, pad_out, pad_pull_en, pad_pull_up;
    logic [63:0] pad_alt;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 pclk = ~pclk;

    pinbank_ctrl u_pinbank_ctrl (
        .pclk        (pclk),
        .presetn     (presetn),
        .psel        (psel),
        .penable     (penable),
        .pwrite      (pwrite),
        .paddr       (paddr),
        .pwdata      (pwdata),
        .prdata      (prdata),
        .pad_in      (pad_in),
        .pad_oe      (pad_oe),
        .pad_out     (pad_out),
        .pad_pull_en (pad_pull_en),
        .pad_pull_up (pad_pull_up),
        .pad_alt     (pad_alt)
    );

    // {tag, offset, write data, expected pad_out, expected pad_oe}
    localparam int NVEC = 9;
    localparam logic [119:0] VEC [0:NVEC-1] = '{
        {"R2", 8'h00, 32'hA5A5_0F0F, 32'hA5A5_0F0F, 32'h0000_0000},
        {"R3", 8'h04, 32'h0000_F0F0, 32'hA5A5_FFFF, 32'h0000_0000},
        {"R4", 8'h08, 32'hA500_000F, 32'h00A5_FFF0, 32'h0000_0000},
        {"R5", 8'h10, 32'hFFFF_0000, 32'h00A5_FFF0, 32'hFFFF_0000},
        {"R5", 8'h14, 32'h0000_00FF, 32'h00A5_FFF0, 32'hFFFF_00FF},
        {"R5", 8'h18, 32'h0F00_0001, 32'h00A5_FFF0, 32'hF0FF_00FE},
        {"R11", 8'h1C, 32'hFFFF_FFFF, 32'h00A5_FFF0, 32'hF0FF_00FE},
        {"R11", 8'h40, 32'hFFFF_FFFF, 32'h00A5_FFF0, 32'hF0FF_00FE},
        {"R3", 8'h04, 32'h0000_0000, 32'h00A5_FFF0, 32'hF0FF_00FE}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge pclk);
        penable = 1'b1;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    // combinational read, consumes no clock edge
    task automatic peek(input logic [7:0] a, output logic [31:0] d);
        psel = 1'b1; penable = 1'b1; pwrite = 1'b0; paddr = a;
        #1;
        d = prdata;
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge pclk);
        errors++;
        $display("FAIL watchdog actual hung expected finished");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        presetn = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        paddr = '0; pwdata = '0; pad_in = '0;
        repeat (3) @(posedge pclk);
        @(negedge pclk);
        presetn = 1'b1;

        // R1 reset state
        chk("R1 oe", pad_oe, 32'h0);
        chk("R1 out", pad_out, 32'h0);
        chk("R1 pull_en", pad_pull_en, 32'hFFFF_FFFF);
        chk("R1 pull_up", pad_pull_up, 32'h0);
        chk("R1 alt_lo", pad_alt[31:0], 32'h0);
        chk("R1 alt_hi", pad_alt[63:32], 32'h0);
        peek(8'h10, rd); chk("R1 dir rd", rd, 32'h0);
        peek(8'h0C, rd); chk("R1 pulloff rd", rd, 32'h0);

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            string tg;
            tg = $sformatf("%s", VEC[i][119:104]);
            bus_write(VEC[i][103:96], VEC[i][95:64]);
            chk({tg, " out"}, pad_out, VEC[i][63:32]);
            chk({tg, " oe"}, pad_oe, VEC[i][31:0]);
        end

        // R6 pull tracks stored level on inputs; R7 none on drivers
        chk("R7 pull_en", pad_pull_en, 32'h0F00_FF01);
        chk("R6 pull_up", pad_pull_up, 32'h00A5_FFF0);
        bus_write(8'h0C, 32'h0000_0101);
        chk("R6 pull_en", pad_pull_en, 32'h0F00_FE00);
        bus_write(8'h04, 32'h8000_0000);
        chk("R7 out", pad_out, 32'h80A5_FFF0);
        chk("R7 pull_en", pad_pull_en, 32'h0F00_FE00);
        chk("R6 pull_up", pad_pull_up, 32'h80A5_FFF0);

        // R8 function code packing
        bus_write(8'h20, 32'h0000_0003);
        bus_write(8'h24, 32'h0000_0006);
        chk("R8 alt_lo", pad_alt[31:0], 32'h0000_002D);
        chk("R8 alt_hi", pad_alt[63:32], 32'h0);

        // R10 readback
        peek(8'h0C, rd); chk("R10 pulloff", rd, 32'h0000_0101);
        peek(8'h10, rd); chk("R10 dir", rd, 32'hF0FF_00FE);
        peek(8'h20, rd); chk("R10 fn_a", rd, 32'h0000_0003);
        peek(8'h24, rd); chk("R10 fn_b", rd, 32'h0000_0006);
        peek(8'h04, rd); chk("R10 lvl set", rd, 32'h0);
        peek(8'h08, rd); chk("R10 lvl clr", rd, 32'h0);
        peek(8'h14, rd); chk("R10 dir set", rd, 32'h0);
        peek(8'h18, rd); chk("R10 dir clr", rd, 32'h0);

        // R11 unmapped reads
        peek(8'h1C, rd); chk("R11 rd 1C", rd, 32'h0);
        peek(8'h40, rd); chk("R11 rd 40", rd, 32'h0);

        // R12 setup phase alone writes nothing
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 8'h00; pwdata = 32'hFFFF_FFFF;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b1; paddr = 8'h10;
        @(negedge pclk);
        penable = 1'b0; pwrite = 1'b0;
        @(negedge pclk);
        chk("R12 out", pad_out, 32'h80A5_FFF0);
        chk("R12 oe", pad_oe, 32'hF0FF_00FE);

        // R9 synchroniser latency
        @(negedge pclk);
        pad_in = 32'h1234_5678;
        peek(8'h00, rd); chk("R9 before", rd, 32'h0);
        @(negedge pclk);
        peek(8'h00, rd); chk("R9 one edge", rd, 32'h0);
        @(negedge pclk);
        peek(8'h00, rd); chk("R9 two edges", rd, 32'h1234_5678);

        // R1 reset again from a busy state
        @(negedge pclk);
        presetn = 1'b0;
        @(negedge pclk);
        chk("R1 re oe", pad_oe, 32'h0);
        chk("R1 re out", pad_out, 32'h0);
        chk("R1 re alt", pad_alt[31:0], 32'h0);
        presetn = 1'b1;

        finish_run();
    end

endmodule